// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds wall-clock time and a calendar as packed BCD digits: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle 1 Hz enable from an external prescaler moves the whole chain forward by one second. The carry runs from seconds through minutes and hours into the date digits. The date digits take account of month lengths and a selectable leap-year phase. Hours count in either 24-hour or 12-hour form. The mode bit and the afternoon flag share a nibble with the hour-tens digit.

Time is loaded one digit at a time through a single write port. Each write selects a digit by a 4-bit index and takes effect on the next clock edge. A hold input freezes counting. A clear input drops the tick that arrives with it, so the counting restarts from a clean phase. Writes are trusted to be legal BCD. The block checks nothing.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the outputs read 00:00:00 in 24-hour mode, PM 0, day of week 0, day 01, month 01, year 00, leap phase 00.
- R2: Each effective tick adds one second. Second and minute units count 0..9 and their tens count 0..5. 59 seconds becomes 00 and carries into minutes, and 59 minutes becomes 00 and carries into hours.
- R3: In 24-hour mode the hour counts 00..23. The step from 23 to 00 advances the date by one day. The hour-tens write nibble is laid out as follows: bit 3 = 1 selects 24-hour mode, bit 2 is PM and bits 1:0 are the tens digit.
- R4: In 12-hour mode the hour runs 12, 01, ... 11. PM inverts on the step from 11 to 12. The step from 11 PM to 12 AM advances the date.
- R5: In 24-hour mode PM reads 0, even if a write sets bit 2.
- R6: The day of month rolls to 01 and the month advances after day 31, after day 30 for months 4, 6, 9 and 11, and after day 28 for a February that is not a leap year.
- R7: Bits 3:2 of the day-tens nibble are the leap phase. Phase 00 makes a year with remainder 0 mod 4 a leap year, 01 remainder 3, 10 remainder 2 and 11 remainder 1. A leap February ends at day 29. Day rollover leaves the phase unchanged.
- R8: Month 12 rolls to 01 and advances the year. Year 99 rolls to 00.
- R9: The day of week counts 0..6 and advances in the same step as the day of month.
- R10: While hold is high, ticks have no effect. Writes still take effect.
- R11: A tick that arrives with clear high is discarded.
- R12: Write index map: 0 second units, 1 second tens, 2 minute units, 3 minute tens, 4 hour units, 5 hour tens/mode/PM, 6 day of week, 7 day units, 8 day tens/leap phase, 9 month units, 10 month tens, 11 year units, 12 year tens. Indices 13..15 change nothing. A write shows on the outputs one cycle later.
- R13: A tick that arrives in the same cycle as a write is dropped whole. The written digit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle 1 Hz advance enable |
| hold | input | 1 | Freeze counting |
| clr | input | 1 | Clear: discard the coincident tick |
| wr_en | input | 1 | Digit write strobe |
| wr_sel | input | 4 | Digit index |
| wr_data | input | 4 | Digit value / packed flags |
| sec_u | output | 4 | Seconds units |
| sec_t | output | 3 | Seconds tens |
| min_u | output | 4 | Minutes units |
| min_t | output | 3 | Minutes tens |
| hr_u | output | 4 | Hours units |
| hr_t | output | 2 | Hours tens |
| mode24 | output | 1 | 1 = 24-hour mode |
| pm | output | 1 | Afternoon flag (12-hour mode) |
| dow | output | 3 | Day of week 0..6 |
| day_u | output | 4 | Day units |
| day_t | output | 2 | Day tens |
| leap_sel | output | 2 | Leap-year phase |
| mon_u | output | 4 | Month units |
| mon_t | output | 1 | Month tens |
| yr_u | output | 4 | Year units |
| yr_t | output | 4 | Year tens |

## Verification
A digit write and a counting tick can land in the same cycle. The write must win and the whole tick must vanish, even when the tick would carry into the digit that is being written. Random runs on states placed a few seconds before a rollover raise a tick together with a seconds write at random. Directed cases put a tick on top of a minutes write. A bench model makes the judgement: on a write it applies only the write and on a tick only the tick, and it compares every output digit one cycle later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DOW_W = 3;

  typedef enum logic [3:0] {
    IX_SEC_U = 4'd0,  IX_SEC_T = 4'd1,  IX_MIN_U = 4'd2,  IX_MIN_T = 4'd3,
    IX_HR_U  = 4'd4,  IX_HR_T  = 4'd5,  IX_DOW   = 4'd6,  IX_DAY_U = 4'd7,
    IX_DAY_T = 4'd8,  IX_MON_U = 4'd9,  IX_MON_T = 4'd10, IX_YR_U  = 4'd11,
    IX_YR_T  = 4'd12
  } digit_ix_e;

  typedef struct packed {
    logic       m24;
    logic       pm;
    logic [1:0] tens;
    logic [3:0] units;
  } hour_t;

  typedef struct packed {
    logic  carry;
    hour_t h;
  } hour_res_t;

  // {wrap, next} for one BCD digit counting 0..last
  function automatic logic [4:0] digit_next(logic [3:0] d, logic [3:0] last);
    logic w;
    w = (d == last);
    return {w, w ? 4'd0 : d + 4'd1};
  endfunction

  // one hour step; carry marks the start of a new day
  function automatic hour_res_t hour_step(hour_t h);
    hour_res_t r;
    r.h     = h;
    r.carry = 1'b0;
    if (h.m24) begin
      r.h.pm = 1'b0;
      if (h.tens == 2'd2 && h.units == 4'd3) begin
        r.h.tens  = 2'd0;
        r.h.units = 4'd0;
        r.carry   = 1'b1;
      end else if (h.units == 4'd9) begin
        r.h.tens  = h.tens + 2'd1;
        r.h.units = 4'd0;
      end else begin
        r.h.units = h.units + 4'd1;
      end
    end else begin
      if (h.tens == 2'd1 && h.units == 4'd2) begin
        r.h.tens  = 2'd0;
        r.h.units = 4'd1;
      end else if (h.tens == 2'd1 && h.units == 4'd1) begin
        r.h.units = 4'd2;
        r.h.pm    = ~h.pm;
        r.carry   = h.pm;
      end else if (h.units == 4'd9) begin
        r.h.tens  = 2'd1;
        r.h.units = 4'd0;
      end else begin
        r.h.units = h.units + 4'd1;
      end
    end
    return r;
  endfunction

  // leap test: (year mod 4 + phase) mod 4 == 0, year mod 4 = (2*tens + units) mod 4
  function automatic logic year_is_leap(logic [3:0] yt, logic [3:0] yu, logic [1:0] phase);
    logic [4:0] s;
    s = {yt, 1'b0} + {1'b0, yu} + {3'b000, phase};
    return (s[1:0] == 2'd0);
  endfunction

  // last day of the month as BCD {tens, units}
  function automatic logic [5:0] month_last_day(logic mt, logic [3:0] mu,
                                                logic [3:0] yt, logic [3:0] yu,
                                                logic [1:0] phase);
    if (!mt && mu == 4'd2)
      return year_is_leap(yt, yu, phase) ? {2'd2, 4'd9} : {2'd2, 4'd8};
    else if ((!mt && (mu == 4'd4 || mu == 4'd6 || mu == 4'd9)) || (mt && mu == 4'd1))
      return {2'd3, 4'd0};
    else
      return {2'd3, 4'd1};
  endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter logic RST_MODE24 = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [3:0] wr_data,
  output logic [3:0] sec_u,
  output logic [2:0] sec_t,
  output logic [3:0] min_u,
  output logic [2:0] min_t,
  output hour_t      hour,
  output logic       hr_step,
  output logic       day_step
);

  logic [4:0] su_n, st_n, mu_n, mt_n;
  logic       sec_wrap;
  hour_res_t  h_n;

  always_comb begin
    su_n     = digit_next(sec_u, 4'd9);
    st_n     = digit_next({1'b0, sec_t}, 4'd5);
    mu_n     = digit_next(min_u, 4'd9);
    mt_n     = digit_next({1'b0, min_t}, 4'd5);
    sec_wrap = step & su_n[4] & st_n[4];
    hr_step  = sec_wrap & mu_n[4] & mt_n[4];
    h_n      = hour_step(hour);
    day_step = hr_step & h_n.carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_u <= '0;
      sec_t <= '0;
      min_u <= '0;
      min_t <= '0;
      hour  <= '{m24: RST_MODE24, pm: 1'b0, tens: 2'd0, units: 4'd0};
    end else if (wr_en) begin
      case (wr_sel)
        IX_SEC_U: sec_u <= wr_data;
        IX_SEC_T: sec_t <= wr_data[2:0];
        IX_MIN_U: min_u <= wr_data;
        IX_MIN_T: min_t <= wr_data[2:0];
        IX_HR_U:  hour.units <= wr_data;
        IX_HR_T: begin
          hour.m24  <= wr_data[3];
          hour.pm   <= wr_data[2] & ~wr_data[3];
          hour.tens <= wr_data[1:0];
        end
        default: ;
      endcase
    end else begin
      if (step)             sec_u <= su_n[3:0];
      if (step & su_n[4])   sec_t <= st_n[2:0];
      if (sec_wrap)         min_u <= mu_n[3:0];
      if (sec_wrap & mu_n[4]) min_t <= mt_n[2:0];
      if (hr_step)          hour  <= h_n.h;
    end
  end

  p_sec_digits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_u <= 4'd9 && sec_t <= 3'd5 && min_u <= 4'd9 && min_t <= 3'd5);

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec_u == 4'd0 && sec_t == 3'd0));

  p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && hour.m24) |=> (hour.tens == 2'd0 && hour.units == 4'd0));

  p_noon_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_step && !hour.m24 && hour.tens == 2'd1 && hour.units == 4'd1) |=> (hour.pm != $past(hour.pm)));

  p_pm_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hour.m24 |-> !hour.pm);

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
#(
  parameter int WEEK_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             day_step,
  input  logic             wr_en,
  input  logic [3:0]       wr_sel,
  input  logic [3:0]       wr_data,
  output logic [DOW_W-1:0] dow,
  output logic [3:0]       day_u,
  output logic [1:0]       day_t,
  output logic [1:0]       leap_sel,
  output logic [3:0]       mon_u,
  output logic             mon_t,
  output logic [3:0]       yr_u,
  output logic [3:0]       yr_t
);

  localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(WEEK_LEN - 1);

  logic [5:0] last_day;
  logic       day_end, mon_end, mon_step, year_step;
  logic [4:0] yu_n, yt_n;

  always_comb begin
    last_day  = month_last_day(mon_t, mon_u, yr_t, yr_u, leap_sel);
    day_end   = ({day_t, day_u} == last_day);
    mon_end   = mon_t && (mon_u == 4'd2);
    mon_step  = day_step & day_end;
    year_step = mon_step & mon_end;
    yu_n      = digit_next(yr_u, 4'd9);
    yt_n      = digit_next(yr_t, 4'd9);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow      <= '0;
      day_u    <= 4'd1;
      day_t    <= 2'd0;
      leap_sel <= 2'd0;
      mon_u    <= 4'd1;
      mon_t    <= 1'b0;
      yr_u     <= 4'd0;
      yr_t     <= 4'd0;
    end else if (wr_en) begin
      case (wr_sel)
        IX_DOW:   dow <= wr_data[DOW_W-1:0];
        IX_DAY_U: day_u <= wr_data;
        IX_DAY_T: begin
          leap_sel <= wr_data[3:2];
          day_t    <= wr_data[1:0];
        end
        IX_MON_U: mon_u <= wr_data;
        IX_MON_T: mon_t <= wr_data[0];
        IX_YR_U:  yr_u  <= wr_data;
        IX_YR_T:  yr_t  <= wr_data;
        default: ;
      endcase
    end else begin
      if (day_step) begin
        dow <= (dow == DOW_LAST) ? '0 : dow + 1'b1;
        if (day_end) begin
          day_t <= 2'd0;
          day_u <= 4'd1;
        end else if (day_u == 4'd9) begin
          day_t <= day_t + 2'd1;
          day_u <= 4'd0;
        end else begin
          day_u <= day_u + 4'd1;
        end
      end
      if (mon_step) begin
        if (mon_end) begin
          mon_t <= 1'b0;
          mon_u <= 4'd1;
        end else if (mon_u == 4'd9) begin
          mon_t <= 1'b1;
          mon_u <= 4'd0;
        end else begin
          mon_u <= mon_u + 4'd1;
        end
      end
      if (year_step) begin
        yr_u <= yu_n[3:0];
        if (yu_n[4]) yr_t <= yt_n[3:0];
      end
    end
  end

  p_dow_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dow <= DOW_LAST);

  p_dow_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_en) |=> (dow != $past(dow)));

  p_month_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_step && !wr_en) |=> (day_t == 2'd0 && day_u == 4'd1));

  p_phase_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_en) |=> $stable(leap_sel));

  p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (year_step && !wr_en && yr_t == 4'd9 && yr_u == 4'd9) |=> (yr_t == 4'd0 && yr_u == 4'd0));

  p_newyear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (year_step && !wr_en) |=> (mon_t == 1'b0 && mon_u == 4'd1));

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import rtc_pkg::*;
#(
  parameter logic RST_MODE24 = 1'b1,
  parameter int   WEEK_LEN   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       hold,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [3:0] wr_data,
  output logic [3:0] sec_u,
  output logic [2:0] sec_t,
  output logic [3:0] min_u,
  output logic [2:0] min_t,
  output logic [3:0] hr_u,
  output logic [1:0] hr_t,
  output logic       mode24,
  output logic       pm,
  output logic [2:0] dow,
  output logic [3:0] day_u,
  output logic [1:0] day_t,
  output logic [1:0] leap_sel,
  output logic [3:0] mon_u,
  output logic       mon_t,
  output logic [3:0] yr_u,
  output logic [3:0] yr_t
);

  logic  advance;
  logic  hr_step;
  logic  day_step;
  hour_t hour;
  logic [45:0] all_digits;

  // write beats clear, clear beats hold, hold beats tick
  assign advance = tick_1hz & ~hold & ~clr & ~wr_en;

  rtc_time_chain #(.RST_MODE24(RST_MODE24)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (advance),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .sec_u    (sec_u),
    .sec_t    (sec_t),
    .min_u    (min_u),
    .min_t    (min_t),
    .hour     (hour),
    .hr_step  (hr_step),
    .day_step (day_step)
  );

  rtc_date_chain #(.WEEK_LEN(WEEK_LEN)) u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_step (day_step),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .dow      (dow),
    .day_u    (day_u),
    .day_t    (day_t),
    .leap_sel (leap_sel),
    .mon_u    (mon_u),
    .mon_t    (mon_t),
    .yr_u     (yr_u),
    .yr_t     (yr_t)
  );

  assign hr_u   = hour.units;
  assign hr_t   = hour.tens;
  assign mode24 = hour.m24;
  assign pm     = hour.pm;

  assign all_digits = {sec_u, sec_t, min_u, min_t, hr_u, hr_t, mode24, pm, dow,
                       day_u, day_t, leap_sel, mon_u, mon_t, yr_u, yr_t};

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(all_digits));

  p_clear_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_en) |=> $stable(all_digits));

  p_write_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == IX_SEC_U) |=> (sec_u == $past(wr_data)));

  p_bad_index_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > IX_YR_T) |=> $stable(all_digits));

endmodule

// File: tb/bcd_calendar_core_bench.sv
module bcd_calendar_core_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, hold = 1'b0, clr = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_sel = '0, wr_data = '0;
  logic [3:0] sec_u, min_u, hr_u, day_u, mon_u, yr_u, yr_t;
  logic [2:0] sec_t, min_t, dow;
  logic [1:0] hr_t, day_t, leap_sel;
  logic mode24, pm, mon_t;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state as plain integers
  int m_sec, m_min, m_ht, m_hu, m_m24, m_pm, m_dow, m_day, m_ls, m_mon, m_yr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_core u_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .hold(hold), .clr(clr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_u(sec_u), .sec_t(sec_t), .min_u(min_u), .min_t(min_t),
    .hr_u(hr_u), .hr_t(hr_t), .mode24(mode24), .pm(pm), .dow(dow),
    .day_u(day_u), .day_t(day_t), .leap_sel(leap_sel), .mon_u(mon_u),
    .mon_t(mon_t), .yr_u(yr_u), .yr_t(yr_t)
  );

  function automatic int days_of(int mon, int yr, int ls);
    bit leap;
    leap = ((yr % 4) == ((4 - ls) % 4));
    case (mon)
      2: return leap ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [45:0] expected();
    return {4'(m_sec % 10), 3'(m_sec / 10), 4'(m_min % 10), 3'(m_min / 10),
            4'(m_hu), 2'(m_ht), 1'(m_m24), 1'(m_pm), 3'(m_dow),
            4'(m_day % 10), 2'(m_day / 10), 2'(m_ls),
            4'(m_mon % 10), 1'(m_mon / 10), 4'(m_yr % 10), 4'(m_yr / 10)};
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_ht = 0; m_hu = 0; m_m24 = 1; m_pm = 0;
    m_dow = 0; m_day = 1; m_ls = 0; m_mon = 1; m_yr = 0;
  endtask

  task automatic model_write(int s, int d);
    case (s)
      0:  m_sec = (m_sec / 10) * 10 + d;
      1:  m_sec = m_sec % 10 + 10 * (d % 8);
      2:  m_min = (m_min / 10) * 10 + d;
      3:  m_min = m_min % 10 + 10 * (d % 8);
      4:  m_hu = d;
      5:  begin m_m24 = d / 8; m_pm = (d / 8) ? 0 : (d / 4) % 2; m_ht = d % 4; end
      6:  m_dow = d % 8;
      7:  m_day = (m_day / 10) * 10 + d;
      8:  begin m_ls = d / 4; m_day = m_day % 10 + 10 * (d % 4); end
      9:  m_mon = (m_mon / 10) * 10 + d;
      10: m_mon = m_mon % 10 + 10 * (d % 2);
      11: m_yr = (m_yr / 10) * 10 + d;
      12: m_yr = m_yr % 10 + 10 * d;
      default: ;
    endcase
  endtask

  // the clock walks as a 0..23 integer; display form is derived from it
  task automatic model_tick();
    int h24;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0;
    h24 = m_m24 ? (m_ht * 10 + m_hu) : ((m_ht * 10 + m_hu) % 12 + (m_pm ? 12 : 0));
    h24 = (h24 + 1) % 24;
    if (m_m24) begin
      m_ht = h24 / 10; m_hu = h24 % 10; m_pm = 0;
    end else begin
      int h12;
      h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
      m_ht = h12 / 10; m_hu = h12 % 10; m_pm = (h24 >= 12);
    end
    if (h24 != 0) return;
    m_dow = (m_dow + 1) % 7;
    if (m_day < days_of(m_mon, m_yr, m_ls)) begin m_day++; return; end
    m_day = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    m_yr = (m_yr + 1) % 100;
  endtask

  task automatic check(string tag);
    logic [45:0] act;
    act = {sec_u, sec_t, min_u, min_t, hr_u, hr_t, mode24, pm, dow,
           day_u, day_t, leap_sel, mon_u, mon_t, yr_u, yr_t};
    n_checks++;
    if (act !== expected()) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expected());
    end
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic cyc(bit t, bit h, bit c, bit w, int s, int d, string tag);
    tick_1hz = t; hold = h; clr = c; wr_en = w;
    wr_sel = 4'(s); wr_data = 4'(d);
    @(posedge clk);
    if (w) model_write(s, d);
    else if (!c && !h && t) model_tick();
    @(negedge clk);
    tick_1hz = 0; hold = 0; clr = 0; wr_en = 0;
    check(tag);
  endtask

  task automatic tick(string tag);
    cyc(1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic set_state(int sec, int mn, int m24, int hr, int p, int dw,
                           int day, int mon, int yr, int ls);
    cyc(0, 0, 0, 1, 0,  sec % 10, "R12");
    cyc(0, 0, 0, 1, 1,  sec / 10, "R12");
    cyc(0, 0, 0, 1, 2,  mn % 10, "R12");
    cyc(0, 0, 0, 1, 3,  mn / 10, "R12");
    cyc(0, 0, 0, 1, 4,  hr % 10, "R12");
    cyc(0, 0, 0, 1, 5,  m24 * 8 + p * 4 + hr / 10, "R12");
    cyc(0, 0, 0, 1, 6,  dw, "R12");
    cyc(0, 0, 0, 1, 7,  day % 10, "R12");
    cyc(0, 0, 0, 1, 8,  ls * 4 + day / 10, "R12");
    cyc(0, 0, 0, 1, 9,  mon % 10, "R12");
    cyc(0, 0, 0, 1, 10, mon / 10, "R12");
    cyc(0, 0, 0, 1, 11, yr % 10, "R12");
    cyc(0, 0, 0, 1, 12, yr / 10, "R12");
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset state");

    // R2 R3 R8 R9: year-end midnight in 24-hour mode
    set_state(58, 59, 1, 23, 0, 6, 31, 12, 99, 0);
    tick("R2 seconds step");
    tick("R3 R8 R9 full rollover");
    // R12 unused index
    cyc(0, 0, 0, 1, 13, 5, "R12 index 13 ignored");
    cyc(0, 0, 0, 1, 15, 9, "R12 index 15 ignored");
    // R10 hold
    cyc(1, 1, 0, 0, 0, 0, "R10 hold tick");
    cyc(1, 1, 0, 0, 0, 0, "R10 hold tick");
    cyc(1, 1, 0, 1, 0, 7, "R10 write during hold");
    tick("R10 released");
    // R11 clear
    cyc(1, 0, 1, 0, 0, 0, "R11 clear drops tick");
    // R13 collision on minute units at a carry
    set_state(59, 59, 1, 10, 0, 2, 15, 6, 20, 1);
    cyc(1, 0, 0, 1, 2, 3, "R13 write beats tick");
    tick("R13 after collision");
    // R5
    cyc(0, 0, 0, 1, 5, 4'b1110, "R5 pm forced low");

    // R4 12-hour cases
    set_state(59, 59, 0, 11, 0, 3, 10, 5, 30, 0);
    tick("R4 11AM to 12PM");
    set_state(59, 59, 0, 12, 1, 3, 10, 5, 30, 0);
    tick("R4 12PM to 01PM");
    set_state(59, 59, 0, 11, 1, 3, 15, 5, 30, 0);
    tick("R4 11PM to 12AM next day");
    set_state(59, 59, 0, 12, 0, 3, 15, 5, 30, 0);
    tick("R4 12AM to 01AM");

    // R6 R7 month ends
    set_state(59, 59, 1, 23, 0, 0, 28, 2, 96, 0);
    tick("R7 leap Feb 28 phase 00");
    set_state(59, 59, 1, 23, 0, 0, 29, 2, 96, 0);
    tick("R7 leap Feb 29 end");
    set_state(59, 59, 1, 23, 0, 0, 28, 2, 97, 0);
    tick("R6 plain Feb 28 end");
    set_state(59, 59, 1, 23, 0, 0, 28, 2, 97, 3);
    tick("R7 phase 11 remainder 1");
    set_state(59, 59, 1, 23, 0, 0, 28, 2, 99, 1);
    tick("R7 phase 01 remainder 3");
    set_state(59, 59, 1, 23, 0, 0, 28, 2, 98, 2);
    tick("R7 phase 10 remainder 2");
    set_state(59, 59, 1, 23, 0, 5, 30, 4, 10, 0);
    tick("R6 April 30 end");
    set_state(59, 59, 1, 23, 0, 5, 30, 1, 10, 0);
    tick("R6 January 30 not end");
    set_state(59, 59, 1, 23, 0, 5, 30, 11, 10, 0);
    tick("R6 November 30 end");
    set_state(59, 59, 1, 23, 0, 5, 29, 9, 19, 0);
    tick("R6 R8 September 29 to 30");

    // random runs around rollovers
    for (int it = 0; it < 40; it++) begin
      int m24, hr, p, mon, yr, ls, day;
      m24 = $urandom % 2;
      p   = $urandom % 2;
      hr  = m24 ? (22 + $urandom % 2) : (11 + $urandom % 2);
      mon = 1 + $urandom % 12;
      yr  = $urandom % 100;
      ls  = $urandom % 4;
      day = days_of(mon, yr, ls) - $urandom % 2;
      set_state(50 + $urandom % 10, 58 + $urandom % 2, m24, hr, m24 ? 0 : p,
                $urandom % 7, day, mon, yr, ls);
      for (int k = 0; k < 150; k++) begin
        int r;
        r = $urandom % 100;
        if (r < 3)       cyc(1, 0, 0, 1, 0, $urandom % 10, "R13 random collision");
        else if (r < 7)  cyc($urandom % 2, 0, 1, 0, 0, 0, "R11 random clear");
        else if (r < 15) cyc($urandom % 2, 1, 0, 0, 0, 0, "R10 random hold");
        else             cyc(($urandom % 100) < 85, 0, 0, 0, 0, 0, "R2 R4 R9 random count");
      end
    end

    report();
  end

endmodule